// File: doc/BRIEF.md
# SPI Byte FIFO and Interrupt Controller

This block sits between a register bus and a serial shift engine. It holds two byte queues: a transmit queue that software fills and the shift engine drains, and a receive queue that the shift engine fills and software drains. Each queue has a programmable trigger level and an occupancy count. The shift engine also sees each count directly on a port.

Four event sources feed one interrupt line. Two are threshold events: receive occupancy at or above its trigger, and transmit occupancy at or below its trigger. The other two are a receive overflow and a transfer-complete pulse from the shift engine. Every event has a sticky status bit that is cleared by writing one to it, and an enable bit of its own. Software can empty either queue by writing a self-clearing flush bit. The queue depth is a parameter and may be 64 or 128 entries.

The register file has four word addresses on a 2-bit address: 0 interrupt enable, 1 interrupt status, 2 queue configuration, 3 queue levels. Reads are combinational.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: While reset is held, both queue levels read 0, the enable, status and configuration words read 0, and `irq` is 0.
- R2: Each queue returns bytes in the order they were accepted. Its level goes up by one for each accepted push and down by one for each accepted pop, and is unchanged when both happen in the same cycle. Address 3 reports the receive level in bits 7:0 and the transmit level in bits 23:16, and the core level ports carry the same values.
- R3: A push into a full queue is dropped, so the level stays at DEPTH and the contents do not change. A pop from an empty queue is ignored and the level stays 0.
- R4: A shift-engine push into a full receive queue sets status bit 8 at the next clock edge, and the byte is dropped.
- R5: Status bit 0 is set at the clock edge after the receive level is greater than or equal to the receive trigger (address 2, bits 7:0).
- R6: Status bit 4 is set at the clock edge after the transmit level is less than or equal to the transmit trigger (address 2, bits 23:16).
- R7: A one-cycle `core_xfer_done` pulse sets status bit 12 at the next clock edge.
- R8: Writing address 1 clears each status bit written as 1 and leaves the bits written as 0 unchanged. Writing all ones clears every bit. A clear takes priority over a set in the same cycle. Status bits stay set until they are cleared.
- R9: If a threshold condition still holds after its bit has been cleared, the bit is set again at the following clock edge.
- R10: Writing 1 to address 2 bit 15 (receive) or bit 31 (transmit) empties that queue at the same clock edge. The flush bit reads 1 for one cycle and then returns to 0. The trigger fields are written by the same write.
- R11: `irq` is the OR over bits 0, 4, 8 and 12 of the status word ANDed with the enable word at address 0. Only those four enable bits are stored; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_tx_push | input | 1 | Software push into the transmit queue |
| host_tx_data | input | 8 | Byte to push into the transmit queue |
| host_rx_pop | input | 1 | Software pop from the receive queue |
| host_rx_data | output | 8 | Head of the receive queue |
| core_tx_pop | input | 1 | Shift engine pop from the transmit queue |
| core_tx_data | output | 8 | Head of the transmit queue |
| core_tx_level | output | $clog2(DEPTH+1) | Transmit queue occupancy |
| core_rx_push | input | 1 | Shift engine push into the receive queue |
| core_rx_data | input | 8 | Byte pushed by the shift engine |
| core_rx_level | output | $clog2(DEPTH+1) | Receive queue occupancy |
| core_xfer_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
A bad pointer or level register shows up at the head-data port on the next pop as a byte out of order, and in the level word in the same cycle. A threshold comparison against the wrong bound moves the status bit by exactly one edge, so the bench samples the edge before and the edge after each crossing. A clear that loses to a set, or a stuck flush bit, shows in the first status or configuration read after the write. Mixed random push and pop traffic checks the level after every edge against a reference queue.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

    localparam int DATA_W  = 8;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int FIELD_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_IRQ_EN   = 2'd0,
        A_IRQ_STAT = 2'd1,
        A_Q_CFG    = 2'd2,
        A_Q_LVL    = 2'd3
    } reg_addr_e;

    // bit positions of the interrupt word, decoded by software
    localparam int B_RX_RDY   = 0;
    localparam int B_TX_REQ   = 4;
    localparam int B_RX_OVF   = 8;
    localparam int B_XFER_END = 12;

    // queue configuration and level word fields
    localparam int RX_TRIG_LSB = 0;
    localparam int RX_FLUSH_B  = 15;
    localparam int TX_TRIG_LSB = 16;
    localparam int TX_FLUSH_B  = 31;
    localparam int RX_LVL_LSB  = 0;
    localparam int TX_LVL_LSB  = 16;

    typedef struct packed {
        logic xfer_end;
        logic rx_ovf;
        logic tx_req;
        logic rx_rdy;
    } irq_vec_t;

    typedef struct packed {
        logic [FIELD_W-1:0] tx_trig;
        logic [FIELD_W-1:0] rx_trig;
        logic               tx_flush;
        logic               rx_flush;
    } q_cfg_t;

    function automatic irq_vec_t word_to_irq(input logic [REG_W-1:0] w);
        irq_vec_t v;
        v.rx_rdy   = w[B_RX_RDY];
        v.tx_req   = w[B_TX_REQ];
        v.rx_ovf   = w[B_RX_OVF];
        v.xfer_end = w[B_XFER_END];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] irq_to_word(input irq_vec_t v);
        logic [REG_W-1:0] w;
        w               = '0;
        w[B_RX_RDY]     = v.rx_rdy;
        w[B_TX_REQ]     = v.tx_req;
        w[B_RX_OVF]     = v.rx_ovf;
        w[B_XFER_END]   = v.xfer_end;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input q_cfg_t c);
        logic [REG_W-1:0] w;
        w                                  = '0;
        w[RX_TRIG_LSB +: FIELD_W]          = c.rx_trig;
        w[TX_TRIG_LSB +: FIELD_W]          = c.tx_trig;
        w[RX_FLUSH_B]                      = c.rx_flush;
        w[TX_FLUSH_B]                      = c.tx_flush;
        return w;
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             push_drop
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    assign full      = (level == CNT_W'(DEPTH));
    assign empty     = (level == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH)); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> (level == '0)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0)); // R10

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_fifo_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t evt,
    input  irq_vec_t clr,
    input  logic     en_wr,
    input  irq_vec_t en_wdata,
    output irq_vec_t status,
    output irq_vec_t enable,
    output logic     irq
);

    irq_vec_t status_nxt;

    always_comb begin
        status_nxt = irq_vec_t'((status | evt) & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= status_nxt;
            if (en_wr) enable <= en_wdata;
        end
    end

    assign irq = |(status & enable);

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr.xfer_end |=> !status.xfer_end); // R8
    AST_STICKY_OVF: assert property (@(posedge clk) disable iff (rst)
        (status.rx_ovf && !clr.rx_ovf) |=> status.rx_ovf); // R8
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (evt.rx_ovf && !clr.rx_ovf) |=> status.rx_ovf); // R4
    AST_END_SET: assert property (@(posedge clk) disable iff (rst)
        (evt.xfer_end && !clr.xfer_end) |=> status.xfer_end); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq); // R11

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              core_tx_pop,
    output logic [DATA_W-1:0] core_tx_data,
    output logic [CNT_W-1:0]  core_tx_level,
    input  logic              core_rx_push,
    input  logic [DATA_W-1:0] core_rx_data,
    output logic [CNT_W-1:0]  core_rx_level,
    input  logic              core_xfer_done,
    output logic              irq
);

    reg_addr_e addr;
    q_cfg_t    cfg;
    irq_vec_t  evt, clr, status, enable;
    logic      wr_en, wr_stat, wr_cfg;
    logic      tx_flush_now, rx_flush_now;
    logic      tx_full, rx_full, tx_drop, rx_drop;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_en   = reg_wr && (addr == A_IRQ_EN);
    assign wr_stat = reg_wr && (addr == A_IRQ_STAT);
    assign wr_cfg  = reg_wr && (addr == A_Q_CFG);

    assign tx_flush_now = wr_cfg && reg_wdata[TX_FLUSH_B];
    assign rx_flush_now = wr_cfg && reg_wdata[RX_FLUSH_B];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            cfg.tx_flush <= tx_flush_now;
            cfg.rx_flush <= rx_flush_now;
            if (wr_cfg) begin
                cfg.rx_trig <= reg_wdata[RX_TRIG_LSB +: FIELD_W];
                cfg.tx_trig <= reg_wdata[TX_TRIG_LSB +: FIELD_W];
            end
        end
    end

    spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush_now),
        .push      (host_tx_push),
        .push_data (host_tx_data),
        .pop       (core_tx_pop),
        .head      (core_tx_data),
        .level     (core_tx_level),
        .full      (tx_full),
        .push_drop (tx_drop)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush_now),
        .push      (core_rx_push),
        .push_data (core_rx_data),
        .pop       (host_rx_pop),
        .head      (host_rx_data),
        .level     (core_rx_level),
        .full      (rx_full),
        .push_drop (rx_drop)
    );

    always_comb begin
        evt.rx_rdy   = FIELD_W'(core_rx_level) >= cfg.rx_trig;
        evt.tx_req   = FIELD_W'(core_tx_level) <= cfg.tx_trig;
        evt.rx_ovf   = rx_drop;
        evt.xfer_end = core_xfer_done;
        clr          = wr_stat ? word_to_irq(reg_wdata) : irq_vec_t'('0);
    end

    spi_irq_status u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr      (clr),
        .en_wr    (wr_en),
        .en_wdata (word_to_irq(reg_wdata)),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (addr)
            A_IRQ_EN:   reg_rdata = irq_to_word(enable);
            A_IRQ_STAT: reg_rdata = irq_to_word(status);
            A_Q_CFG:    reg_rdata = cfg_to_word(cfg);
            A_Q_LVL: begin
                reg_rdata[RX_LVL_LSB +: FIELD_W] = FIELD_W'(core_rx_level);
                reg_rdata[TX_LVL_LSB +: FIELD_W] = FIELD_W'(core_tx_level);
            end
            default:    reg_rdata = '0;
        endcase
    end

    AST_TX_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        (cfg.tx_flush && !tx_flush_now) |=> !cfg.tx_flush); // R10
    AST_RX_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        (cfg.rx_flush && !rx_flush_now) |=> !cfg.rx_flush); // R10
    AST_OVF_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (rx_full && core_rx_push && !host_rx_pop && !rx_flush_now) |=> rx_full); // R4
    AST_TX_REQ_TRACK: assert property (@(posedge clk) disable iff (rst)
        (evt.tx_req && !clr.tx_req) |=> status.tx_req); // R6

endmodule

// File: tb/tb_spi_fifo_irq_ctrl.sv
module tb_spi_fifo_irq_ctrl;

    localparam int DEPTH = 128;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 0;
    logic             rst = 1;
    logic             reg_wr = 0;
    logic [1:0]       reg_addr = 0;
    logic [31:0]      reg_wdata = 0;
    logic [31:0]      reg_rdata;
    logic             host_tx_push = 0;
    logic [7:0]       host_tx_data = 0;
    logic             host_rx_pop = 0;
    logic [7:0]       host_rx_data;
    logic             core_tx_pop = 0;
    logic [7:0]       core_tx_data;
    logic [CNT_W-1:0] core_tx_level;
    logic             core_rx_push = 0;
    logic [7:0]       core_rx_data = 0;
    logic [CNT_W-1:0] core_rx_level;
    logic             core_xfer_done = 0;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_fifo_irq_ctrl #(.DEPTH(DEPTH)) dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] en);
        return |(st & en & 32'h0000_1111);
    endfunction

    function automatic logic [31:0] lvl_word(input int rxl, input int txl);
        return (32'(txl) << 16) | 32'(rxl);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [31:0] v, st, en;
        logic [7:0]  q[$];
        logic [7:0]  b;
        void'($urandom(32'h5EED_1234));

        repeat (3) tick();
        // R1 reset state
        rd(2'd3, v); check(v == 0 && core_tx_level == 0 && core_rx_level == 0, "R1 levels", v, 0);
        rd(2'd1, v); check(v == 0 && irq == 0, "R1 status/irq", v, 0);
        tick();
        rd(2'd0, v); check(v == 0, "R1 enable", v, 0);
        rd(2'd2, v); check(v == 0, "R1 config", v, 0);
        rst = 0;
        tick();

        // triggers: rx 3, tx 2
        wr(2'd2, 32'h0002_0003);
        wr(2'd1, 32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) begin
            host_tx_push = 1; host_tx_data = 8'hA1 + 8'(i); tick();
        end
        host_tx_push = 0;
        rd(2'd3, v); check(v == lvl_word(0, 5) && core_tx_level == 5, "R2 tx level", v, lvl_word(0, 5));
        wr(2'd1, 32'h0000_0010);
        rd(2'd1, v); check(v[4] == 0, "R8 clear tx bit", v, 0);
        for (int i = 0; i < 3; i++) begin
            check(core_tx_data == 8'hA1 + 8'(i), "R2 tx order", core_tx_data, 8'hA1 + 8'(i));
            core_tx_pop = 1; tick();
        end
        core_tx_pop = 0;
        rd(2'd1, v); check(v[4] == 0, "R6 not yet", v, 0);
        tick();
        rd(2'd1, v); check(v[4] == 1, "R6 tx request set", v, 32'h10);

        // R9 re-assert after clear
        wr(2'd1, 32'h0000_0010);
        rd(2'd1, v); check(v[4] == 0, "R9 cleared", v, 0);
        tick();
        rd(2'd1, v); check(v[4] == 1, "R9 re-asserted", v, 32'h10);

        // R11 enable and irq
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, en); check(en == 32'h0000_1111, "R11 enable readback", en, 32'h1111);
        wr(2'd0, 32'h0000_0010);
        rd(2'd1, st); rd(2'd0, en);
        check(irq == exp_irq(st, en) && irq == 1, "R11 irq on", irq, 1);
        wr(2'd0, 32'h0000_1000);
        rd(2'd1, st); rd(2'd0, en);
        check(irq == exp_irq(st, en) && irq == 0, "R11 irq masked", irq, 0);

        // R7 transfer end
        core_xfer_done = 1; tick(); core_xfer_done = 0;
        rd(2'd1, v); check(v[12] == 1 && irq == 1, "R7 xfer end", v, 32'h1010);

        // R8 selective and full clear
        wr(2'd1, 32'h0000_1000);
        rd(2'd1, v); check(v == 32'h0000_0010, "R8 selective clear", v, 32'h10);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check(v == 0, "R8 clear all", v, 0);
        wr(2'd0, 32'h0);

        // R10 transmit flush
        wr(2'd2, 32'h8002_0003);
        rd(2'd2, v); check(v == 32'h8002_0003, "R10 flush bit visible", v, 32'h8002_0003);
        rd(2'd3, v); check(v == 0, "R10 tx emptied", v, 0);
        tick();
        rd(2'd2, v); check(v == 32'h0002_0003, "R10 flush self-clear", v, 32'h0002_0003);

        // R5 receive ready
        wr(2'd1, 32'hFFFF_FFFF);
        q.delete();
        for (int i = 0; i < 3; i++) begin
            core_rx_push = 1; core_rx_data = 8'h30 + 8'(i); q.push_back(core_rx_data); tick();
        end
        core_rx_push = 0;
        rd(2'd1, v); check(v[0] == 0, "R5 not yet", v, 0);
        tick();
        rd(2'd1, v); check(v[0] == 1, "R5 rx ready", v, 1);

        // R4 overflow
        for (int i = 3; i < DEPTH; i++) begin
            core_rx_push = 1; core_rx_data = 8'(i) ^ 8'h5A; q.push_back(core_rx_data); tick();
        end
        core_rx_push = 0;
        rd(2'd3, v); check(v == lvl_word(DEPTH, 0), "R2 rx full level", v, lvl_word(DEPTH, 0));
        rd(2'd1, v); check(v[8] == 0, "R4 no overflow yet", v, 0);
        core_rx_push = 1; core_rx_data = 8'hEE; tick(); core_rx_push = 0;
        rd(2'd1, v); check(v[8] == 1, "R4 overflow set", v, 32'h100);
        check(core_rx_level == CNT_W'(DEPTH), "R4 level held", core_rx_level, DEPTH);
        while (q.size() > 0) begin
            b = q.pop_front();
            check(host_rx_data == b, "R4 rx order, byte dropped", host_rx_data, b);
            host_rx_pop = 1; tick();
        end
        host_rx_pop = 0;
        check(core_rx_level == 0, "R2 rx drained", core_rx_level, 0);
        host_rx_pop = 1; tick(); host_rx_pop = 0;
        check(core_rx_level == 0, "R3 pop empty ignored", core_rx_level, 0);

        // R10 receive flush
        for (int i = 0; i < 4; i++) begin
            core_rx_push = 1; core_rx_data = 8'(i); tick();
        end
        core_rx_push = 0;
        wr(2'd2, 32'h0002_8003);
        check(core_rx_level == 0, "R10 rx emptied", core_rx_level, 0);

        // R3 transmit full
        for (int i = 0; i <= DEPTH; i++) begin
            host_tx_push = 1; host_tx_data = 8'h10 + 8'(i); tick();
        end
        host_tx_push = 0;
        check(core_tx_level == CNT_W'(DEPTH), "R3 full level", core_tx_level, DEPTH);
        check(core_tx_data == 8'h10, "R3 contents kept", core_tx_data, 8'h10);
        wr(2'd2, 32'h8002_0003);

        // random traffic on the transmit queue
        q.delete();
        for (int n = 0; n < 3000; n++) begin
            bit p, o;
            int sz;
            p = ($urandom % 3) != 0;
            o = ($urandom % 2) != 0;
            sz = q.size();
            host_tx_push = p; host_tx_data = 8'($urandom);
            core_tx_pop = o;
            if (o && sz > 0) begin
                b = q.pop_front();
                check(core_tx_data == b, "R2 random order", core_tx_data, b);
            end
            if (p && sz < DEPTH) q.push_back(host_tx_data);
            tick();
            check(core_tx_level == CNT_W'(q.size()), "R2 random level", core_tx_level, q.size());
        end
        host_tx_push = 0; core_tx_pop = 0;

        finished = 1;
        summary();
    end

endmodule